// File: doc/BRIEF.md
# Soft-Start Duty Ramp Sequencer

This block brings a multiphase buck converter from cold to regulation before the hysteretic loop takes over. When enable rises, it captures the requested output level from a voltage-identification code. It turns that level into a target in ADC sample units and scales the target by a programmable fraction to get a start threshold. It then drives every phase with the same fixed-period PWM waveform. The ramp is closed-loop: the duty begins at a small value and grows by a fixed step at each period boundary, as long as the measured output has stayed at or below the threshold.

Once a valid output sample lands above the threshold, the sequencer stops driving the gates and raises a hand-off flag. The hysteretic controller watches that flag to know it now owns the power stage. The flag stays set until enable is withdrawn. The duty is clamped below full on-time, so the high-side switch always turns off at least once per period.

Top module: `softstart_seq`

## Requirements
- R1: While reset is asserted or `en` is low, `hs_en`, `ls_en` and `ss_done` are all zero, and they are zero on the first clock edge after `en` falls.
- R2: On the clock edge where an idle sequencer sees `en` high, the threshold is captured as floor((VBASE + vid_code*VSTEP) * thr_frac / 2^FRAC_W). Later changes of `vid_code` or `thr_frac` do not alter it until the next start.
- R3: During the ramp the PWM period is PERIOD clocks. A position counter runs from 0 to PERIOD-1 starting at 0 on the first ramp cycle, every `hs_en` bit is 1 exactly while the counter is below the current duty, and all phases carry the same value.
- R4: During the ramp each `ls_en` bit is the inverse of the matching `hs_en` bit, so exactly one of the two is high per phase.
- R5: The first ramp period uses a duty of DUTY_INIT clocks.
- R6: At the last cycle of a period, if at least one valid sample arrived in that period, the duty of the next period is raised by DUTY_STEP. A period with no valid sample keeps its duty. The duty never changes inside a period.
- R7: The raised duty saturates at min(`duty_cap`, PERIOD-1).
- R8: A valid sample strictly greater than the threshold during the ramp sets `ss_done` and drives all gate enables low from the next cycle. A sample equal to the threshold does not. This takes precedence over a duty step falling in the same cycle.
- R9: `ss_done` stays set, with the gates low, while `en` stays high, whatever samples arrive. Dropping `en` clears it, and a new start begins again at DUTY_INIT.
- R10: `vsamp` is ignored whenever `vsamp_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Start request; low returns to idle |
| vid_code | input | VID_W | Requested output level code |
| thr_frac | input | FRAC_W | Threshold fraction of target, in 1/2^FRAC_W units |
| duty_cap | input | CNT_W | Upper duty limit in clocks |
| vsamp | input | SAMP_W | Output voltage sample, unsigned |
| vsamp_vld | input | 1 | Sample strobe |
| hs_en | output | PHASES | High-side gate enables, one per phase |
| ls_en | output | PHASES | Low-side gate enables, one per phase |
| ss_done | output | 1 | Hand-off flag to the hysteretic controller |

## Verification
Two events can coincide. A sample that crosses the threshold can arrive on the final cycle of a PWM period, where a duty step is also due. The bench waits until its reference position reaches PERIOD-1 and strobes an above-threshold sample exactly there. It then expects the hand-off to win: gates low and `ss_done` high on the next cycle, with no extra PWM pulse. A second collision pairs that crossing sample with `en` falling in the same cycle. Here the drop of enable must win, and the output must be idle with `ss_done` low.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RAMP = 2'd1,
    SS_DONE = 2'd2
  } ss_state_e;
endpackage

// File: rtl/ss_vid_thr.sv
module ss_vid_thr #(
  parameter int VID_W  = 6,
  parameter int SAMP_W = 12,
  parameter int FRAC_W = 8,
  parameter int VBASE  = 1024,
  parameter int VSTEP  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [VID_W-1:0]  vid_code,
  input  logic [FRAC_W-1:0] thr_frac,
  output logic [SAMP_W-1:0] thr_q
);
  localparam int PROD_W = SAMP_W + FRAC_W + 1;

  logic [PROD_W-1:0] target;
  logic [PROD_W-1:0] scaled;
  logic [SAMP_W-1:0] thr_calc;
  logic [SAMP_W-1:0] thr_nxt;

  always_comb begin
    target   = PROD_W'(VBASE) + PROD_W'(vid_code) * PROD_W'(VSTEP);
    scaled   = target * PROD_W'(thr_frac);
    thr_calc = SAMP_W'(scaled >> FRAC_W);
    thr_nxt  = capture ? thr_calc : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_nxt;
  end

  a_r2_thr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(thr_q));
endmodule

// File: rtl/ss_ramp_ctrl.sv
module ss_ramp_ctrl
  import ss_pkg::*;
#(
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SAMP_W-1:0] vsamp,
  input  logic              vsamp_vld,
  input  logic [SAMP_W-1:0] thr,
  output logic              start,
  output logic              ramping,
  output logic              done
);
  ss_state_e state_q, state_nxt;
  logic      above;

  always_comb begin
    above     = vsamp_vld && (vsamp > thr);
    state_nxt = state_q;
    if (!en) begin
      state_nxt = SS_IDLE;
    end else begin
      unique case (state_q)
        SS_IDLE: state_nxt = SS_RAMP;
        SS_RAMP: if (above) state_nxt = SS_DONE;
        SS_DONE: state_nxt = SS_DONE;
        default: state_nxt = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SS_IDLE;
    else        state_q <= state_nxt;
  end

  assign start   = (state_q == SS_IDLE) && en;
  assign ramping = (state_q == SS_RAMP);
  assign done    = (state_q == SS_DONE);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en) |=> done);
  a_r9_exit_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!done && !ramping));
  a_r10_no_strobe_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ramping && en && !vsamp_vld) |=> ramping);
endmodule

// File: rtl/ss_pwm.sv
module ss_pwm #(
  parameter int PHASES    = 4,
  parameter int CNT_W     = 10,
  parameter int PERIOD    = 1000,
  parameter int DUTY_INIT = 2,
  parameter int DUTY_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ramping,
  input  logic              smp_seen,
  input  logic [CNT_W-1:0]  duty_cap,
  output logic [PHASES-1:0] hs,
  output logic [PHASES-1:0] ls
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(DUTY_INIT);
  localparam logic [CNT_W:0]   STEP = (CNT_W+1)'(DUTY_STEP);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] duty_q, duty_nxt;
  logic             chk_q, chk_nxt;
  logic             wrap, step;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   sum;
  logic             gate;

  always_comb begin
    wrap = ramping && (cnt_q == LAST);
    step = wrap && (chk_q || smp_seen);
    lim  = (duty_cap > LAST) ? LAST : duty_cap;
    sum  = {1'b0, duty_q} + STEP;

    cnt_nxt = cnt_q;
    chk_nxt = chk_q;
    if (start) begin
      cnt_nxt = '0;
      chk_nxt = 1'b0;
    end else if (ramping) begin
      cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
      chk_nxt = wrap ? 1'b0 : (chk_q || smp_seen);
    end

    duty_nxt = duty_q;
    if (start)     duty_nxt = INIT;
    else if (step) duty_nxt = (sum > {1'b0, lim}) ? lim : sum[CNT_W-1:0];

    gate = ramping && (cnt_q < duty_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      chk_q  <= 1'b0;
    end else begin
      if (start || ramping) cnt_q  <= cnt_nxt;
      if (start || ramping) chk_q  <= chk_nxt;
      if (start || step)    duty_q <= duty_nxt;
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign hs[p] = gate;
    assign ls[p] = ramping && !gate;
  end

  a_r5_init_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (duty_q == INIT));
  a_r6_duty_moves_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> ($past(step) || $past(start)));
  a_r7_cap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (duty_q <= $past(lim)));
  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    ramping |-> (cnt_q <= LAST));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int PHASES    = 4,
  parameter int VID_W     = 6,
  parameter int SAMP_W    = 12,
  parameter int FRAC_W    = 8,
  parameter int CNT_W     = 10,
  parameter int PERIOD    = 1000,
  parameter int DUTY_INIT = 2,
  parameter int DUTY_STEP = 4,
  parameter int VBASE     = 1024,
  parameter int VSTEP     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [VID_W-1:0]  vid_code,
  input  logic [FRAC_W-1:0] thr_frac,
  input  logic [CNT_W-1:0]  duty_cap,
  input  logic [SAMP_W-1:0] vsamp,
  input  logic              vsamp_vld,
  output logic [PHASES-1:0] hs_en,
  output logic [PHASES-1:0] ls_en,
  output logic              ss_done
);
  logic [SAMP_W-1:0] thr;
  logic              start, ramping, done;

  ss_vid_thr #(
    .VID_W(VID_W), .SAMP_W(SAMP_W), .FRAC_W(FRAC_W),
    .VBASE(VBASE), .VSTEP(VSTEP)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .capture(start),
    .vid_code(vid_code), .thr_frac(thr_frac), .thr_q(thr)
  );

  ss_ramp_ctrl #(.SAMP_W(SAMP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en),
    .vsamp(vsamp), .vsamp_vld(vsamp_vld), .thr(thr),
    .start(start), .ramping(ramping), .done(done)
  );

  ss_pwm #(
    .PHASES(PHASES), .CNT_W(CNT_W), .PERIOD(PERIOD),
    .DUTY_INIT(DUTY_INIT), .DUTY_STEP(DUTY_STEP)
  ) u_pwm (
    .clk(clk), .rst_n(rst_n), .start(start), .ramping(ramping),
    .smp_seen(vsamp_vld), .duty_cap(duty_cap),
    .hs(hs_en), .ls(ls_en)
  );

  assign ss_done = done;

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((hs_en == '0) && (ls_en == '0) && !ss_done));
  a_r8_gates_off_after_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> ((hs_en == '0) && (ls_en == '0)));
  a_r4_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en != '0) |-> (ls_en == '0));
endmodule

// File: tb/softstart_seq_tb.sv
`timescale 1ns/1ps
module softstart_seq_tb;
  localparam int PH = 4, VW = 6, SW = 12, FW = 8, CW = 10;
  localparam int P = 20, INIT = 2, STEP = 3, VB = 1024, VS = 16;

  logic clk = 1'b0;
  logic rst_n, en, vld;
  logic [VW-1:0] vid;
  logic [FW-1:0] frac;
  logic [CW-1:0] cap;
  logic [SW-1:0] vs;
  logic [PH-1:0] hs, ls;
  logic done;

  always #2.5 clk = ~clk;

  softstart_seq #(
    .PHASES(PH), .VID_W(VW), .SAMP_W(SW), .FRAC_W(FW), .CNT_W(CW),
    .PERIOD(P), .DUTY_INIT(INIT), .DUTY_STEP(STEP), .VBASE(VB), .VSTEP(VS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .vid_code(vid), .thr_frac(frac),
    .duty_cap(cap), .vsamp(vs), .vsamp_vld(vld),
    .hs_en(hs), .ls_en(ls), .ss_done(done)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  logic [2*PH:0] exp_q[$];
  string tag_q[$];

  // reference model built from the requirements
  int m_st = 0, m_cnt = 0, m_duty = 0, m_thr = 0;
  bit m_chk = 0;

  always @(posedge clk) begin
    int lim, nd;
    bit hb;
    if (!rst_n || !en) m_st = 0;
    else if (m_st == 0) begin
      m_st = 1; m_cnt = 0; m_duty = INIT; m_chk = 0;
      m_thr = ((VB + int'(vid) * VS) * int'(frac)) / 256;
    end else if (m_st == 1) begin
      if (vld && int'(vs) > m_thr) m_st = 2;
      else if (m_cnt == P - 1) begin
        if (m_chk || vld) begin
          lim = (int'(cap) > P - 1) ? P - 1 : int'(cap);
          nd = m_duty + STEP;
          m_duty = (nd > lim) ? lim : nd;
        end
        m_cnt = 0; m_chk = 0;
      end else begin
        m_cnt++; m_chk = m_chk || vld;
      end
    end
    hb = (m_st == 1) && (m_cnt < m_duty);
    exp_q.push_back({{PH{hb}}, {PH{(m_st == 1) && !hb}}, m_st == 2});
    tag_q.push_back(cur_req);
  end

  always @(negedge clk) begin
    logic [2*PH:0] e, a;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {hs, ls, done};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: hs/ls/done actual %b expected %b at %0t", t, a, e, $time);
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic run(int n, int every, int val);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vs  = SW'(val);
      vld = (every > 0) && (i % every == 0);
    end
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic pulse(int val);
    @(negedge clk);
    vs = SW'(val); vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; vld = 1'b0; vs = '0;
    vid = 6'd10; frac = 8'd230; cap = 10'd1023;
    repeat (3) @(negedge clk);
    check("R1", {hs, ls, done}, 0);
    rst_n = 1'b1;
    run(3, 0, 0);

    // threshold = (1024+160)*230/256 = 1063
    cur_req = "R5"; en = 1'b1;
    run(2 * P, 0, 0);                 // no samples: duty stays at start value
    cur_req = "R3"; run(3 * P, 7, 500);
    cur_req = "R4"; run(2 * P, 5, 500);
    cur_req = "R2"; vid = 6'd0; frac = 8'd200;   // would give 800 if re-read
    run(2 * P, 4, 1000);
    cur_req = "R10"; vs = 12'd4000; run(15, 0, 4000);
    cur_req = "R7"; run(12 * P, 3, 500);        // saturates at P-1
    cur_req = "R8";
    pulse(1063);
    check("R8", done, 0);
    pulse(1064);
    check("R8", done, 1);
    cur_req = "R9"; run(10, 2, 100);
    check("R9", done, 1);
    en = 1'b0;
    @(negedge clk);
    check("R9", {hs, ls, done}, 0);

    // second start: cap 9, threshold (1024+320)*128/256 = 672
    vid = 6'd20; frac = 8'd128; cap = 10'd9;
    cur_req = "R7"; en = 1'b1;
    run(8 * P, 5, 100);
    cur_req = "R8";
    while (!(m_st == 1 && m_cnt == P - 1)) @(negedge clk);
    vs = 12'd700; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check("R8", done, 1);
    check("R8", hs, 0);

    cur_req = "R9"; en = 1'b0; run(2, 0, 0);
    en = 1'b1; run(P + 5, 4, 100);
    vs = 12'd900; vld = 1'b1; en = 1'b0;
    @(negedge clk);
    vld = 1'b0;
    check("R9", {hs, ls, done}, 0);
    cur_req = "R1"; run(5, 0, 0);
    finish_run();
  end
endmodule